// File: doc/BRIEF.md
# Key and Input Event Queue

This block collects input events for a host processor and hands them over oldest first. Up to `NSRC` producers feed it: a keypad scanner on source 0, input-change detectors on source 1 and logic-output change detectors on source 2. Each producer offers a 7-bit event number and a state bit, qualified by a valid strobe that lasts one cycle. All sources share one queue of `DEPTH` one-byte entries. The host takes entries through a read port. It sees the head entry, and a pop strobe removes that entry.

The event count, a level interrupt flag and a sticky overflow flag are plain status pins. The host clears each flag with a one-cycle write-1 pulse. On the input side `src_ready` reports whether an event offered on that source in the current cycle will be accepted. The producers cannot be stalled, so they do not wait for `src_ready`: an event offered while it is low is dropped and recorded as an overflow. On the read side `rd_valid` is high while entries are pending. An entry leaves the queue in a cycle where both `rd_valid` and `rd_ready` are high. `rd_data` reads as zero when the queue is empty.

Top module: `evq_top`

## Requirements
- R1: After reset, `evt_count` is 0, `rd_valid`, `int_flag` and `ovf_flag` are 0, `rd_data` is 0x00, and every `src_ready` bit is 1.
- R2: Each entry is one byte with the state bit in bit 7 (1 = press/active, 0 = release/inactive) and the event number in bits 6:0. `rd_data` shows the oldest stored entry while `rd_valid` is 1.
- R3: Entries leave in arrival order, and the queue holds up to `DEPTH` (16) entries. Events accepted in the same cycle are ordered by source index, with source 0 (keys) first, then source 1, then source 2.
- R4: While the queue is empty, `rd_valid` is 0 and `rd_data` is 0x00 (event number 0 means "no event"). A pop while empty changes nothing.
- R5: A strobe whose event number is 0 is ignored: nothing is stored and no flag is changed.
- R6: A pop removes the oldest entry and lowers `evt_count` (5 bits) by one. Every accepted event raises it by one. An accepted entry is visible on the read port in the cycle after its strobe.
- R7: Let F be the free slots, counting a slot freed by a pop in the same cycle. When more live events arrive than F, the lowest-indexed sources are accepted up to F. The rest are discarded, and `ovf_flag` is set in the next cycle.
- R8: `ovf_flag` stays set until an `ovf_clr` pulse. If a discard happens in the same cycle as the pulse, the flag stays set.
- R9: Every accepted event sets `int_flag` in the next cycle, whatever its state bit (press or release).
- R10: `int_flag` stays set until an `int_clr` pulse. After the pulse it is 0 only if the queue is empty and no event was accepted in that cycle; otherwise it stays 1.
- R11: A push and a pop in the same cycle leave `evt_count` unchanged, and this holds when the queue is full.
- R12: `src_ready[i]` is 1 exactly when the live events on lower-indexed sources in that cycle number fewer than F. It does not depend on the source's own valid bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | NSRC | One-cycle event strobe per source |
| src_state | input | NSRC | State bit per source (1 press/active, 0 release) |
| src_code | input | NSRC*7 | Event number per source, source i in bits 7i+6:7i |
| src_ready | output | NSRC | The event on this source would be accepted this cycle |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_ready | input | 1 | Pop strobe from the host |
| rd_data | output | 8 | Head entry, or 0x00 when empty |
| evt_count | output | 5 | Number of stored entries |
| int_flag | output | 1 | Event interrupt level |
| int_clr | input | 1 | Write-1 clear of the interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |

## Verification
The assertions watch several local rules on every cycle. The count never exceeds the depth. A pop alone lowers the count by one, and a single push with a pop keeps it steady. An idle cycle or a zero-code strobe leaves the count alone. An accepted event always raises the interrupt, and a discard always raises the overflow flag. The overflow flag only falls after a clear pulse. Only the bench's scenarios can show the entry contents and their order across sources. They also cover the exact split between accepted and dropped events at every fill level, and the interrupt's re-assertion after a clear. For these the bench sweeps fill levels 0 to 16 against every source mask, with and without a pop, and then runs a long mixed sequence against an arithmetic model.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int EVQ_CODE_W = 7;

  typedef struct packed {
    logic                  state;
    logic [EVQ_CODE_W-1:0] code;
  } evq_entry_t;
endpackage

// File: rtl/evq_merge.sv
module evq_merge #(
  parameter int NSRC  = 3,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  live,
  input  logic [CNT_W-1:0] count,
  input  logic             pop_eff,
  output logic [NSRC-1:0]  ready,
  output logic [NSRC-1:0]  acc,
  output logic [AW-1:0]    slot [NSRC],
  output logic [CNT_W-1:0] n_acc,
  output logic             drop
);
  logic [CNT_W:0]  free;
  logic [CNT_W:0]  rank [NSRC+1];
  logic [NSRC-1:0] lost;

  assign free = (CNT_W+1)'(DEPTH) - {1'b0, count} + {{CNT_W{1'b0}}, pop_eff};
  assign rank[0] = '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_rank
    assign rank[g+1] = rank[g] + {{CNT_W{1'b0}}, live[g]};
    assign ready[g]  = rank[g] < free;
    assign acc[g]    = live[g] && ready[g];
    assign lost[g]   = live[g] && !ready[g];
    assign slot[g]   = AW'(rank[g]);
  end

  assign n_acc = (rank[NSRC] < free) ? CNT_W'(rank[NSRC]) : CNT_W'(free);
  assign drop  = |lost;

  // R12: with room for every source, nothing is refused
  assert_ready_room_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (free >= (CNT_W+1)'(NSRC)) |-> (&ready));
  // R7: a discard only happens when the queue has no slot left for it
  assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (n_acc == CNT_W'(free)));
endmodule

// File: rtl/evq_store.sv
module evq_store #(
  parameter int NSRC  = 3,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     wr_en,
  input  logic [AW-1:0]       wr_slot [NSRC],
  input  evq_pkg::evq_entry_t wr_data [NSRC],
  input  logic [CNT_W-1:0]    n_acc,
  input  logic                pop_eff,
  output logic [CNT_W-1:0]    count,
  output logic [CNT_W-1:0]    count_nxt,
  output evq_pkg::evq_entry_t head
);
  evq_pkg::evq_entry_t mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW-1:0] widx [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_idx
    assign widx[g] = wptr + wr_slot[g];
  end

  assign count_nxt = count + n_acc - {{(CNT_W-1){1'b0}}, pop_eff};
  assign head      = mem[rptr];

  always_ff @(posedge clk) begin
    for (int g = 0; g < NSRC; g++) begin
      if (wr_en[g]) mem[widx[g]] <= wr_data[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + n_acc[AW-1:0];
      count <= count_nxt;
      if (pop_eff) rptr <= rptr + AW'(1);
    end
  end

  // R3: never more than DEPTH entries stored
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R6: a pop with no push lowers the count by one
  assert_pop_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_eff && n_acc == '0) |=> (count == $past(count) - CNT_W'(1)));
  // R11: one push plus one pop keeps the count
  assert_pushpop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_eff && n_acc == CNT_W'(1)) |=> (count == $past(count)));
endmodule

// File: rtl/evq_flags.sv
module evq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic any_acc,
  input  logic drop,
  input  logic pend_nxt,
  input  logic int_clr,
  input  logic ovf_clr,
  output logic int_flag,
  output logic ovf_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (any_acc)      int_flag <= 1'b1;
      else if (int_clr) int_flag <= pend_nxt;

      if (drop)         ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  // R9: an accepted event of either state raises the interrupt
  assert_int_on_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_acc |=> int_flag);
  // R10: without a clear the interrupt cannot fall
  assert_int_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && !int_clr) |=> int_flag);
  // R7: a discard raises the overflow flag
  assert_ovf_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_flag);
  // R8: the overflow flag only falls after a clear pulse
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/evq_top.sv
module evq_top #(
  parameter int NSRC  = 3,
  parameter int DEPTH = 16,
  localparam int CW    = evq_pkg::EVQ_CODE_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_valid,
  input  logic [NSRC-1:0]   src_state,
  input  logic [NSRC*CW-1:0] src_code,
  output logic [NSRC-1:0]   src_ready,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [CW:0]       rd_data,
  output logic [CNT_W-1:0]  evt_count,
  output logic              int_flag,
  input  logic              int_clr,
  output logic              ovf_flag,
  input  logic              ovf_clr
);
  evq_pkg::evq_entry_t ent [NSRC];
  evq_pkg::evq_entry_t head;
  logic [NSRC-1:0]  live, acc;
  logic [AW-1:0]    slot [NSRC];
  logic [CNT_W-1:0] n_acc, count_nxt;
  logic             drop, pop_eff;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign ent[g]  = {src_state[g], src_code[g*CW +: CW]};
    assign live[g] = src_valid[g] && (src_code[g*CW +: CW] != '0);
  end

  assign rd_valid = evt_count != '0;
  assign pop_eff  = rd_valid && rd_ready;
  assign rd_data  = rd_valid ? head : '0;

  evq_merge #(.NSRC(NSRC), .DEPTH(DEPTH)) u_merge (
    .clk(clk), .rst_n(rst_n), .live(live), .count(evt_count),
    .pop_eff(pop_eff), .ready(src_ready), .acc(acc), .slot(slot),
    .n_acc(n_acc), .drop(drop)
  );

  evq_store #(.NSRC(NSRC), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(acc), .wr_slot(slot), .wr_data(ent),
    .n_acc(n_acc), .pop_eff(pop_eff), .count(evt_count),
    .count_nxt(count_nxt), .head(head)
  );

  evq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .any_acc(|acc), .drop(drop),
    .pend_nxt(count_nxt != '0), .int_clr(int_clr), .ovf_clr(ovf_clr),
    .int_flag(int_flag), .ovf_flag(ovf_flag)
  );

  // R5: cycles with no live event and no pop leave the count alone
  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0 && !pop_eff) |=> $stable(evt_count));
  // R4: a pop on an empty queue leaves it empty when nothing arrives
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && live == '0) |=> !rd_valid);
endmodule

// File: tb/tb_evq_top.sv
`timescale 1ns/100ps
module tb_evq_top;
  localparam int NS = 3;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] src_valid = '0, src_state = '0, src_ready;
  logic [NS*7-1:0] src_code = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] evt_count;
  logic int_flag, int_clr = 1'b0, ovf_flag, ovf_clr = 1'b0;

  always #2.5 clk = ~clk;

  evq_top #(.NSRC(NS), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_state(src_state),
    .src_code(src_code), .src_ready(src_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .evt_count(evt_count),
    .int_flag(int_flag), .int_clr(int_clr), .ovf_flag(ovf_flag),
    .ovf_clr(ovf_clr)
  );

  int total = 0, bad = 0;
  int mq [DP];
  int mh = 0, mc = 0;
  bit mi = 0, mo = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    check("R2 R3 R4 rd_data head", rd_data, (mc > 0) ? mq[mh] : 0);
    check("R4 rd_valid", rd_valid, mc > 0);
    check("R6 R11 evt_count", evt_count, mc);
    check("R9 R10 int_flag", int_flag, mi);
    check("R7 R8 ovf_flag", ovf_flag, mo);
  endtask

  // One cycle: drive at negedge, check ready before edge, update model, check after
  task automatic cyc(input logic [2:0] v, input logic [2:0] st,
                     input logic [6:0] c0, input logic [6:0] c1, input logic [6:0] c2,
                     input logic p, input logic ci, input logic co);
    logic [6:0] cd [3];
    logic [2:0] rdy;
    bit acc_any, drp, pe;
    int freeslots, rank;
    int nq [3];
    int na;
    cd[0] = c0; cd[1] = c1; cd[2] = c2;
    src_valid = v; src_state = st; src_code = {c2, c1, c0};
    rd_ready = p; int_clr = ci; ovf_clr = co;
    pe = p && (mc > 0);
    freeslots = DP - mc + (pe ? 1 : 0);
    rank = 0; na = 0; acc_any = 0; drp = 0;
    for (int i = 0; i < 3; i++) begin
      rdy[i] = rank < freeslots;
      if (v[i] && cd[i] != 0) begin
        if (rank < freeslots) begin nq[na] = {st[i], cd[i]}; na++; acc_any = 1; end
        else drp = 1;
        rank++;
      end
    end
    #1;
    check("R12 src_ready", src_ready, rdy);
    @(posedge clk);
    @(negedge clk);
    if (pe) begin mh = (mh + 1) % DP; mc--; end
    for (int k = 0; k < na; k++) begin mq[(mh + mc) % DP] = nq[k]; mc++; end
    if (ci) mi = acc_any || (mc != 0); else mi = mi || acc_any;
    if (drp) mo = 1; else if (co) mo = 0;
    check_outs();
  endtask

  task automatic idle();
    cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 count", evt_count, 0);
    check("R1 int", int_flag, 0);
    check("R1 ovf", ovf_flag, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 ready", src_ready, 3'b111);

    // R4: pop on empty has no effect
    cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b1, 1'b0, 1'b0);
    // R5: zero-code strobes ignored, int stays low
    cyc(3'b111, 3'b111, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 1'b0);
    check("R5 int untouched", int_flag, 0);
    // R9: release event alone sets int; R2 state bit 0
    cyc(3'b001, 3'b000, 7'd5, 7'd0, 7'd0, 1'b0, 1'b0, 1'b0);
    check("R9 release sets int", int_flag, 1);
    check("R2 release entry", rd_data, 8'h05);
    // R10: clear while pending keeps int
    cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b0, 1'b1, 1'b0);
    check("R10 reassert", int_flag, 1);
    // R10: pop last + clear drops int
    cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b1, 1'b1, 1'b0);
    check("R10 cleared", int_flag, 0);
    // R3: same-cycle order by source index
    cyc(3'b111, 3'b101, 7'd3, 7'd40, 7'd90, 1'b0, 1'b0, 1'b0);
    check("R3 first src0", rd_data, 8'h83);
    cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b1, 1'b0, 1'b0);
    check("R3 second src1", rd_data, 8'd40);
    cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b1, 1'b0, 1'b0);
    check("R3 third src2", rd_data, 8'h80 | 8'd90);
    cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b1, 1'b1, 1'b0);

    // Sweep: every fill level x source mask x pop x zero-code on source 1
    for (int lv = 0; lv <= DP; lv++) begin
      for (int m = 0; m < 8; m++) begin
        for (int p = 0; p < 2; p++) begin
          for (int z = 0; z < 2; z++) begin
            while (mc > 0) cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b1, 1'b1, 1'b1);
            idle();
            for (int k = 0; k < lv; k++)
              cyc(3'b001, 3'(k), 7'(1 + k), 7'd0, 7'd0, 1'b0, 1'b0, 1'b0);
            // R7 R11 R12 at this fill level
            cyc(3'(m), 3'(m + lv), 7'(20 + lv), z ? 7'd0 : 7'(50 + lv), 7'(100 + m),
                1'(p), 1'b0, 1'b0);
          end
        end
      end
    end

    // R8: drop in the same cycle as clear keeps ovf set
    while (mc < DP) cyc(3'b111, 3'b010, 7'd7, 7'd8, 7'd9, 1'b0, 1'b0, 1'b0);
    cyc(3'b001, 3'b000, 7'd11, 7'd0, 7'd0, 1'b0, 1'b0, 1'b1);
    check("R8 set wins", ovf_flag, 1);
    cyc(3'b000, 3'b000, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 1'b1);
    check("R8 cleared", ovf_flag, 0);
    // R11: push and pop at full keep count at 16
    cyc(3'b100, 3'b100, 7'd0, 7'd0, 7'd77, 1'b1, 1'b0, 1'b0);
    check("R11 full push+pop", evt_count, DP);
    check("R11 no drop", ovf_flag, 0);

    // Mixed long run
    lf = 16'hACE1;
    for (int t = 0; t < 6000; t++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[2:0], lf[5:3], 7'(lf[12:6]), 7'(lf[15:9] ^ 7'd3), 7'(lf[10:4]),
          ((t / 400) % 2 == 1) ? (lf[11] | lf[13]) : (lf[11] & lf[13]),
          lf[14] & lf[7], lf[15] & lf[8] & lf[1]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule